// File: doc/BRIEF.md
# Second-Order One-Bit Delta-Sigma Modulator

This block is a synthesizable digital model of a second-order, single-bit delta-sigma modulator. On every enabled clock it takes one signed input word and emits one output bit. Over many clocks the fraction of ones in the stream follows the average input. The loop holds two cascaded integrators and a sign comparator. A one-bit feedback value, whose polarity comes from the previous decision, is subtracted at the input of each integrator. The second integrator subtracts it with double weight, which gives second-order noise shaping with a clean two-clock signal delay.

The input is scaled so that the stream does not swing across the whole 0 to 100 percent range of density. A positive full-scale word gives 80 percent ones, a negative full-scale word gives 20 percent ones, and zero gives 50 percent. This margin keeps the loop well inside its stable region. It is set by two parameters: an input gain and a feedback gain, expressed in units of half the input range. Both integrators saturate rather than wrap. A downstream decimation filter, which is not part of this block, samples the bit on the falling clock edge.

Top module: `dsm2_modulator`

## Requirements
- R1: While the synchronous reset is high, both integrators are cleared to zero and the output bit is 0 after the next rising edge.
- R2: A clock with the enable low changes neither the output bit nor either integrator, so the stream resumes exactly where it paused.
- R3: With a constant zero input, the share of ones over 4096 output bits is 50% within ±1%.
- R4: With the positive full-scale input (+32767), the share of ones over 4096 bits is 80% within ±1%.
- R5: With the negative full-scale input (-32768), the share of ones over 4096 bits is 20% within ±1%.
- R6: For inputs between full scale, the share of ones is 50% + 30% × input / 32768, within ±1% over 4096 bits.
- R7: Both integrators clamp at their signed limits instead of wrapping; an accumulator never moves against the sign of its increment, and a long full-scale run keeps the density on target.
- R8: The output bit is 1 when the second integrator, just updated, is zero or positive, and 0 otherwise. The feedback used on a clock is +F for a previous bit of 1 and -F for 0. From reset with zero input, the first four bits are 1, 1, 0, 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock; state updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Clock enable; one output bit per enabled clock |
| sample_i | input | 16 | Signed input word, two's complement |
| bit_o | output | 1 | Modulator output bit, stable for falling-edge sampling |

## Verification
The startup sequence after reset is compared bit by bit. A design with the feedback polarity inverted, a one-clock extra delay on the decision, or the wrong tie rule at zero produces a different first four bits. A pause with the enable low is followed by the continuation of that same sequence, which catches a design that keeps clocking its integrators or drops the output while idle. Density is measured at zero, at both full-scale ends and at two intermediate points. A wrong input or feedback gain moves the density off the 20–80% line, and an unstable or wrapping loop drifts away from it during the long full-scale run.

// File: rtl/dsm2_pkg.sv
package dsm2_pkg;

   // Comparator decision; also the polarity of the feedback value on the next clock
   typedef enum logic {
      DEC_NEG = 1'b0,
      DEC_POS = 1'b1
   } dec_e;

endpackage

// File: rtl/dsm2_feedback.sv
module dsm2_feedback
   import dsm2_pkg::*;
#(
   parameter int IN_W    = 16,
   parameter int FB_GAIN = 5,
   parameter int FBW     = 19
) (
   input  dec_e                  dec_i,
   output logic signed [FBW:0]   fb1_o,
   output logic signed [FBW:0]   fb2_o
);

   localparam logic signed [FBW:0] MAG  = (FBW+1)'(FB_GAIN) <<< (IN_W - 1);
   localparam logic signed [FBW:0] MAG2 = MAG <<< 1;

   generate
      if (MAG2 <= 0) begin : g_bad_width
         $error("dsm2_feedback: FBW too small for the feedback magnitude");
      end
   endgenerate

   always_comb begin
      if (dec_i == DEC_POS) begin
         fb1_o = MAG;
         fb2_o = MAG2;
      end else begin
         fb1_o = -MAG;
         fb2_o = -MAG2;
      end
   end

endmodule

// File: rtl/dsm2_integrator.sv
module dsm2_integrator #(
   parameter int W        = 22,
   parameter int SUM_W    = 26,
   parameter bit SATURATE = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    en,
   input  logic signed [SUM_W-1:0] inc_i,
   output logic signed [W-1:0]     acc_o,
   output logic signed [W-1:0]     nxt_o
);

   localparam logic signed [SUM_W-1:0] MAXV = (SUM_W'(1) <<< (W - 1)) - SUM_W'(1);
   localparam logic signed [SUM_W-1:0] MINV = -MAXV - SUM_W'(1);

   generate
      if (SUM_W < W + 2) begin : g_bad_sum
         $error("dsm2_integrator: SUM_W must exceed W by at least two bits");
      end
   endgenerate

   logic signed [W-1:0]     acc_q;
   logic signed [SUM_W-1:0] sum;

   assign sum = SUM_W'(acc_q) + inc_i;

   generate
      if (SATURATE) begin : g_clamp
         always_comb begin
            if (sum > MAXV)      nxt_o = MAXV[W-1:0];
            else if (sum < MINV) nxt_o = MINV[W-1:0];
            else                 nxt_o = sum[W-1:0];
         end

         // R7: a positive increment never lowers the accumulator, a negative one never raises it
         a_r7_no_wrap_up : assert property (@(posedge clk) disable iff (rst)
            (en && inc_i > 0) |=> (acc_o >= $past(acc_o)));
         a_r7_no_wrap_down : assert property (@(posedge clk) disable iff (rst)
            (en && inc_i < 0) |=> (acc_o <= $past(acc_o)));
      end else begin : g_wrap
         assign nxt_o = sum[W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)     acc_q <= '0;
      else if (en) acc_q <= nxt_o;
   end

   assign acc_o = acc_q;

endmodule

// File: rtl/dsm2_quantizer.sv
module dsm2_quantizer
   import dsm2_pkg::*;
#(
   parameter int W = 24
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                en,
   input  logic signed [W-1:0] level_i,
   output dec_e                dec_o
);

   dec_e dec_q;

   always_ff @(posedge clk) begin
      if (rst)     dec_q <= DEC_NEG;
      else if (en) dec_q <= (level_i >= 0) ? DEC_POS : DEC_NEG;
   end

   assign dec_o = dec_q;

endmodule

// File: rtl/dsm2_modulator.sv
module dsm2_modulator
   import dsm2_pkg::*;
#(
   parameter int IN_W     = 16,
   parameter int IN_GAIN  = 3,
   parameter int FB_GAIN  = 5,
   parameter int I1_HEAD  = 3,
   parameter int I2_HEAD  = 5,
   parameter bit SATURATE = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   en,
   input  logic signed [IN_W-1:0] sample_i,
   output logic                   bit_o
);

   localparam int FBW = IN_W + $clog2(FB_GAIN + 1);
   localparam int I1W = FBW + I1_HEAD;
   localparam int I2W = FBW + I2_HEAD;
   localparam int SW  = I2W + 2;

   generate
      if (IN_GAIN < 1 || FB_GAIN <= IN_GAIN) begin : g_bad_gain
         $error("dsm2_modulator: need 1 <= IN_GAIN < FB_GAIN for a stable loop");
      end
      if (I1_HEAD < 2 || I2_HEAD < I1_HEAD) begin : g_bad_head
         $error("dsm2_modulator: integrator headroom too small");
      end
   endgenerate

   // Input scaling
   logic signed [FBW-1:0] u_scaled;

   generate
      if (IN_GAIN == 1) begin : g_unity
         assign u_scaled = FBW'(sample_i);
      end else begin : g_gain
         logic signed [FBW-1:0] sx;
         logic signed [FBW-1:0] gain_c;
         assign sx       = FBW'(sample_i);
         assign gain_c   = FBW'(IN_GAIN);
         assign u_scaled = sx * gain_c;
      end
   endgenerate

   // Loop
   dec_e                  dec;
   logic signed [FBW:0]   fb1;
   logic signed [FBW:0]   fb2;
   logic signed [I1W-1:0] i1;
   logic signed [I1W-1:0] i1_nxt;
   logic signed [I2W-1:0] i2;
   logic signed [I2W-1:0] i2_nxt;
   logic signed [SW-1:0]  inc1;
   logic signed [SW-1:0]  inc2;

   dsm2_feedback #(
      .IN_W    (IN_W),
      .FB_GAIN (FB_GAIN),
      .FBW     (FBW)
   ) u_fb (
      .dec_i (dec),
      .fb1_o (fb1),
      .fb2_o (fb2)
   );

   assign inc1 = SW'(u_scaled) - SW'(fb1);
   assign inc2 = SW'(i1) - SW'(fb2);

   dsm2_integrator #(
      .W        (I1W),
      .SUM_W    (SW),
      .SATURATE (SATURATE)
   ) u_int1 (
      .clk   (clk),
      .rst   (rst),
      .en    (en),
      .inc_i (inc1),
      .acc_o (i1),
      .nxt_o (i1_nxt)
   );

   dsm2_integrator #(
      .W        (I2W),
      .SUM_W    (SW),
      .SATURATE (SATURATE)
   ) u_int2 (
      .clk   (clk),
      .rst   (rst),
      .en    (en),
      .inc_i (inc2),
      .acc_o (i2),
      .nxt_o (i2_nxt)
   );

   dsm2_quantizer #(
      .W (I2W)
   ) u_q (
      .clk     (clk),
      .rst     (rst),
      .en      (en),
      .level_i (i2_nxt),
      .dec_o   (dec)
   );

   assign bit_o = (dec == DEC_POS);

   // R1: reset clears the loop state and the output
   a_r1_reset_clears : assert property (@(posedge clk)
      rst |=> (!bit_o && i1 == '0 && i2 == '0));

   // R2: an idle clock leaves everything untouched
   a_r2_idle_holds : assert property (@(posedge clk) disable iff (rst)
      !en |=> ($stable(bit_o) && $stable(i1) && $stable(i2)));

   // R8: the registered decision agrees with the sign of the stored second integrator
   a_r8_decision_tracks_state : assert property (@(posedge clk) disable iff (rst)
      en |=> (bit_o == !i2[I2W-1]));

   // unused low-order observation of the first integrator's next value
   logic unused_ok;
   assign unused_ok = ^i1_nxt;

endmodule

// File: tb/dsm2_modulator_tb.sv
module dsm2_modulator_tb;

   typedef struct {
      logic  exp;
      string req;
   } item_t;

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic               en  = 1'b0;
   logic signed [15:0] sample = '0;
   logic               bit_o;

   int    checks = 0;
   int    errors = 0;
   item_t sb_q[$];
   bit    done = 1'b0;

   always #5 clk = ~clk;

   dsm2_modulator u_dut (
      .clk      (clk),
      .rst      (rst),
      .en       (en),
      .sample_i (sample),
      .bit_o    (bit_o)
   );

   // Monitor: compares one expected bit per falling edge
   initial begin
      forever begin
         @(negedge clk);
         if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (bit_o !== it.exp) begin
               errors++;
               $display("FAIL %s bit actual %0b expected %0b", it.req, bit_o, it.exp);
            end
         end
      end
   end

   // Driver: one cycle with the given controls and the bit expected after it
   task automatic drive(input logic r, input logic e, input logic signed [15:0] x,
                        input logic exp, input string req);
      item_t it;
      @(negedge clk);
      #1;
      rst    = r;
      en     = e;
      sample = x;
      it.exp = exp;
      it.req = req;
      sb_q.push_back(it);
   endtask

   task automatic density(input logic signed [15:0] x, input int settle, input string req);
      int  ones;
      int  expc;
      real want;
      @(negedge clk);
      #1;
      rst    = 1'b0;
      en     = 1'b1;
      sample = x;
      for (int i = 0; i < settle; i++) @(negedge clk);
      ones = 0;
      for (int i = 0; i < 4096; i++) begin
         @(negedge clk);
         ones += int'(bit_o);
      end
      want = 4096.0 * (0.5 + 0.3 * real'(x) / 32768.0);
      expc = int'(want);
      checks++;
      if (ones < expc - 41 || ones > expc + 41) begin
         errors++;
         $display("FAIL %s density ones actual %0d expected %0d", req, ones, expc);
      end
   endtask

   initial begin
      // R1: reset state
      drive(1'b1, 1'b0, 16'sd0, 1'b0, "R1");
      drive(1'b1, 1'b1, 16'sd1000, 1'b0, "R1");
      // R8: startup sequence with zero input
      drive(1'b0, 1'b1, 16'sd0, 1'b1, "R8");
      drive(1'b0, 1'b1, 16'sd0, 1'b1, "R8");
      drive(1'b0, 1'b1, 16'sd0, 1'b0, "R8");
      drive(1'b0, 1'b1, 16'sd0, 1'b1, "R8");
      // R2: pause with a large input present; nothing moves
      for (int i = 0; i < 5; i++) drive(1'b0, 1'b0, 16'sd30000, 1'b1, "R2");
      // R2: the sequence then continues from where it paused
      drive(1'b0, 1'b1, 16'sd0, 1'b0, "R2");
      drive(1'b0, 1'b1, 16'sd0, 1'b0, "R2");
      drive(1'b0, 1'b1, 16'sd0, 1'b1, "R2");
      drive(1'b0, 1'b1, 16'sd0, 1'b1, "R2");
      // R1: reset in mid-run, then the startup sequence repeats
      drive(1'b1, 1'b1, 16'sd0, 1'b0, "R1");
      drive(1'b0, 1'b1, 16'sd0, 1'b1, "R1");
      drive(1'b0, 1'b1, 16'sd0, 1'b1, "R1");
      drive(1'b0, 1'b1, 16'sd0, 1'b0, "R1");
      drive(1'b0, 1'b1, 16'sd0, 1'b1, "R1");
      wait (sb_q.size() == 0);
      @(negedge clk);

      density(16'sd0,       256,   "R3");
      density(16'sd32767,   256,   "R4");
      density(-16'sd32768,  256,   "R5");
      density(16'sd16384,   256,   "R6");
      density(-16'sd8192,   256,   "R6");
      // R7: long full-scale runs stay on target with clamping integrators
      density(16'sd32767,   20000, "R7");
      density(-16'sd32768,  20000, "R7");
      density(16'sd0,       512,   "R3");

      done = 1'b1;
   end

   // Watchdog and summary
   initial begin
      for (int i = 0; i < 150000; i++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog run actual hung expected finished");
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule